// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises an active-low interrupt request for a two-port, sixteen-pin I/O expander. It watches the synchronized pin levels. For each port it holds a snapshot of the levels that were last read. While a pin is set up as an input and its level differs from its snapshot bit, the port has a pending change, and the request goes low.

A request clears in one of two ways. The pin can go back to the level held in the snapshot. Or the port's input register can be read, which is signalled by that port's own read strobe and reloads the port's snapshot from the current levels. Each port clears on its own.

Pins set up as outputs are masked, so they never raise a request. When a pin turns from output to input, its snapshot bit takes the pin's level on that change, so the turn itself raises nothing. The open-drain pad driver and the register file sit outside this block.

Top module: `port_chg_irq`

## Requirements
- R1: `irq_n` is low exactly when at least one port has a pending change, and high otherwise.
- R2: While `rst_n` is low, `irq_n` is high. At each clock edge in reset, every snapshot bit loads the current pin level, so once reset ends with the pins unchanged, `irq_n` stays high.
- R3: When a pin with `dir_in` bit = 1 (input) has held that direction for at least one clock edge and its level differs from its snapshot bit, `irq_n` goes low in that same cycle, with no added clock delay.
- R4: A pin with `dir_in` bit = 0 (output) never causes `irq_n` to go low, whatever its level does.
- R5: When a changed input pin returns to its snapshot level, its contribution ends in that same cycle.
- R6: With `rd_strobe[p]` high at a clock edge, port p's snapshot loads the current levels of its pins. Port p is pin bits p*8 to p*8+7, so port 0 is bits 7:0 and port 1 is bits 15:8. From the next cycle, port p's pending change is gone unless a pin changes again.
- R7: A read strobe for one port leaves the snapshot and the pending state of the other port unchanged.
- R8: When a `dir_in` bit goes from 0 to 1, that pin cannot lower `irq_n`, either in the cycle of the change or afterwards, until its level moves away from the level it had at the first clock edge after the change.
- R9: After a read, a later departure from the newly loaded level raises the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | 16 | Synchronized pin levels; bits 7:0 are port 0 and bits 15:8 are port 1 |
| dir_in | input | 16 | Per-pin direction: 1 = input, 0 = output |
| rd_strobe | input | 2 | One-cycle strobe per port, marking a read of that port's input register |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `pin_lvl` and `dir_in` have already been synchronized to `clk`, and that they change only between clock edges. They also assume that a read strobe is only meaningful while `rst_n` is high. The stimulus meets these assumptions by driving every input shortly after a rising edge and sampling `irq_n` on the falling edge.

The sweep uses a pseudo-random generator to flip pins, drive read strobes and toggle directions. A reference model in the bench tracks the snapshots and previous directions from the requirements and predicts every cycle's output.

// File: rtl/port_chg_irq.sv
module port_chg_irq #(
  parameter int PORT_W = 8,
  parameter int NPORT  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT*PORT_W-1:0]   pin_lvl,
  input  logic [NPORT*PORT_W-1:0]   dir_in,
  input  logic [NPORT-1:0]          rd_strobe,
  output logic                      irq_n
);

  localparam int PINS = NPORT * PORT_W;

  logic [PINS-1:0]  snap;
  logic [PINS-1:0]  dir_q;
  logic [PINS-1:0]  load;
  logic [PINS-1:0]  diff;
  logic [NPORT-1:0] pend;

  assign diff = (pin_lvl ^ snap) & dir_in & dir_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign load[p*PORT_W +: PORT_W] = {PORT_W{rd_strobe[p]}}
                                    | (dir_in[p*PORT_W +: PORT_W] & ~dir_q[p*PORT_W +: PORT_W]);
    assign pend[p] = |diff[p*PORT_W +: PORT_W];
  end

  always_ff @(posedge clk) begin
    dir_q <= dir_in;
    if (!rst_n) snap <= pin_lvl;
    else        snap <= (snap & ~load) | (pin_lvl & load);
  end

  assign irq_n = ~rst_n | ~(|pend);

  always_ff @(posedge clk) begin
    if (!rst_n) assert_rst_quiet_R2: assert (irq_n);
  end

  assert_out_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in == '0) |-> irq_n);

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&rd_strobe) |=> (!$stable(pin_lvl) || !$stable(dir_in) || irq_n));

  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && rd_strobe == '0) |=> (!$stable(pin_lvl) || !$stable(dir_in) || irq_n));

endmodule

// File: tb/port_chg_irq_test.sv
module port_chg_irq_test;
  localparam int PERIOD = 10;
  localparam int W = 8;
  localparam int NP = 2;
  localparam int N = W * NP;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] pin = '0;
  logic [N-1:0] dir = '1;
  logic [NP-1:0] rd = '0;
  logic irq_n;

  int total = 0;
  int bad = 0;
  logic [N-1:0] m_snap = '0;
  logic [N-1:0] m_dprev = '0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #(PERIOD/2) clk = ~clk;

  port_chg_irq #(.PORT_W(W), .NPORT(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin), .dir_in(dir),
    .rd_strobe(rd), .irq_n(irq_n));

  function automatic logic model_irq();
    logic [N-1:0] d;
    d = (pin ^ m_snap) & dir & m_dprev;
    return !(rst_n && (d != '0));
  endfunction

  task automatic cyc(input logic r, input logic [N-1:0] p, input logic [N-1:0] d,
                     input logic [NP-1:0] s, input string tag);
    logic e;
    rst_n = r; pin = p; dir = d; rd = s;
    @(negedge clk);
    e = model_irq();
    total++;
    if (irq_n !== e) begin
      bad++;
      $display("FAIL %s: irq_n actual=%b expected=%b pin=%h dir=%h rd=%b",
               tag, irq_n, e, p, d, s);
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (!r || s[i/W] || (d[i] && !m_dprev[i])) m_snap[i] = p[i];
    end
    m_dprev = d;
    #1;
  endtask

  initial begin
    #(PERIOD*200000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    cyc(0, 16'h00A5, '1, '0, "R2 in reset");
    cyc(0, 16'h3C00, '1, '0, "R2 in reset");
    cyc(1, 16'h3C00, '1, '0, "R2 after reset");
    cyc(1, 16'h3C00, '1, '0, "R1 idle");
    cyc(1, 16'h3C08, '1, '0, "R3 port0 change");
    cyc(1, 16'h3C00, '1, '0, "R5 revert");
    cyc(1, 16'h3C08, '1, '0, "R3 port0 change again");
    cyc(1, 16'h3C08, '1, 2'b10, "R7 read port1");
    cyc(1, 16'h3C08, '1, '0, "R7 port0 still pending");
    cyc(1, 16'h3C08, '1, 2'b01, "R6 read port0 strobe cycle");
    cyc(1, 16'h3C08, '1, '0, "R6 cleared");
    cyc(1, 16'h3C00, '1, '0, "R9 departure from new snapshot");
    cyc(1, 16'h3C00, '1, 2'b01, "R9 read");
    cyc(1, 16'h3C00, '1, '0, "R6 cleared");
    cyc(1, 16'h3C00, 16'hFF0F, '0, "R4 dir to output");
    cyc(1, 16'h3CF0, 16'hFF0F, '0, "R4 output pins toggle");
    cyc(1, 16'h3C50, 16'hFF0F, '0, "R4 output pins toggle");
    cyc(1, 16'h3C50, 16'hFFFF, '0, "R8 dir back to input");
    cyc(1, 16'h3C50, 16'hFFFF, '0, "R8 no interrupt after");
    cyc(1, 16'h3C40, 16'hFFFF, '0, "R8 change after turn raises");
    cyc(1, 16'h4C40, 16'hFFFF, 2'b01, "R7 port1 change during port0 read");
    cyc(1, 16'h4C40, 16'hFFFF, '0, "R7 port1 still pending");
    cyc(1, 16'h4C40, 16'hFFFF, 2'b10, "R6 read port1");
    cyc(1, 16'h4C40, 16'hFFFF, '0, "R1 all clear");
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] np;
      logic [N-1:0] nd;
      logic [NP-1:0] ns;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      np = pin;
      if (lfsr[2:0] < 3'd3) np[lfsr[7:4]] = ~np[lfsr[7:4]];
      nd = dir;
      if (lfsr[11:8] == 4'd0) nd[lfsr[15:12]] = ~nd[lfsr[15:12]];
      ns = (lfsr[18:16] == 3'd0) ? lfsr[20:19] : 2'b00;
      cyc(k % 1000 != 999, np, nd, ns, "R1/R3/R4/R5/R6/R7/R8 sweep");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule